// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a reduced-latency DRAM interface and produces the command stream that brings the memory from power-on to its operational state. After a synchronous reset it idles. It waits for an external indication that the core supplies are good. It then holds the command bus idle for a stable-condition interval, which is given in microseconds and converted to clock cycles from the clock frequency.

Once that interval has elapsed, the sequencer writes the mode register three times. The first two writes are throw-away writes that carry an all-zero value. The third write carries the configured mode value. After a mode-settle delay, the sequencer issues one auto-refresh to every bank in ascending bank order, with a fixed spacing between them. After a row-cycle delay following the last refresh, it raises a ready level. From then on the surrounding controller may take over the command bus.

All spacings are start-to-start distances in clock cycles and are exact, so the trace is fully deterministic. On every cycle that carries no mode-register write or refresh, the block drives the idle command.

Top module: `dram_powerup_seq`

## Requirements
- R1: After reset, and for as long as `supply_ok_i` stays low, `cmd_o` is idle (2'b00), `bank_o` is 0, `mode_o` is 0 and `ready_o` is 0.
- R2: The first mode-register write appears exactly STABLE_US*CLK_MHZ clock edges after the first rising edge that samples `supply_ok_i` high.
- R3: Exactly three mode-register writes (code 2'b01) are issued. Each lasts one cycle, and consecutive writes are MRS_GAP cycles apart, start to start.
- R4: `mode_o` is all zeros on the first two mode-register writes, equals `mode_cfg_i` on the third, and is all zeros on every cycle that is not a mode-register write.
- R5: The first refresh is issued exactly T_MRSC cycles after the third mode-register write.
- R6: NUM_BANKS refreshes (code 2'b10) are issued, one per bank, in ascending order from bank 0. Each lasts one cycle, consecutive refreshes are REF_GAP cycles apart, and `bank_o` is 0 on every cycle that is not a refresh.
- R7: `ready_o` rises exactly T_RC cycles after the last refresh and then stays high, with `cmd_o` idle, until reset.
- R8: The command code is always one of idle 2'b00, mode write 2'b01 or refresh 2'b10, and every sequence cycle that is not a scheduled command is idle.
- R9: Asserting the synchronous active-high `rst` at any point clears `ready_o` and returns the block to waiting for `supply_ok_i`. The next run then repeats the full trace from the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Core supplies reported good; sampled only while waiting |
| mode_cfg_i | input | MODE_W | Value to write on the valid mode-register write |
| cmd_o | output | 2 | Command code: 00 idle, 01 mode write, 10 refresh |
| bank_o | output | $clog2(NUM_BANKS) | Bank of the current refresh, else 0 |
| mode_o | output | MODE_W | Mode-register value on a mode write, else 0 |
| ready_o | output | 1 | Sequence complete, held until reset |

## Verification
The embedded assertions check these properties on every cycle:
- the legal command encodings;
- single-cycle commands;
- the rule that a mode value or bank number appears only with its own command;
- the minimum refresh spacing, which is tracked by a saturating counter;
- idle output while waiting for supplies;
- the stickiness of ready, and the quiet bus once ready is high.

The exact cycle positions are shown only by the bench scenarios. These include the stable-interval length, the three write gaps, the mode-settle and row-cycle delays, and the ascending bank order. The bench sweeps supply delays and mode values and compares the outputs cycle by cycle against an arithmetic schedule. The same applies to reset-restart behaviour, both in the middle of the refresh phase and after ready.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_MRS = 2'b01,
        CMD_REF = 2'b10
    } dram_cmd_e;

    typedef enum logic [3:0] {
        ST_WAIT_SUPPLY,
        ST_STABLE,
        ST_MRS,
        ST_MRS_GAP,
        ST_MRS_SETTLE,
        ST_REF,
        ST_REF_GAP,
        ST_ROW_CYCLE,
        ST_READY
    } init_state_e;

    typedef struct packed {
        logic       load;
        logic       mrs_step;
        logic       bank_step;
    } seq_ctrl_t;

    function automatic int unsigned cycles_from_us(input int unsigned us,
                                                   input int unsigned mhz);
        return us * mhz;
    endfunction

    function automatic int unsigned max2(input int unsigned a,
                                         input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned max5(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c,
                                         input int unsigned d,
                                         input int unsigned e);
        return max2(max2(max2(a, b), max2(c, d)), e);
    endfunction

endpackage

// File: rtl/init_interval_timer.sv
module init_interval_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    p_timer_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/init_event_counter.sv
module init_event_counter #(
    parameter int unsigned COUNT = 8,
    localparam int unsigned W = (COUNT > 1) ? $clog2(COUNT) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] value,
    output logic         at_last
);
    localparam logic [W-1:0] LAST = W'(COUNT - 1);

    logic [W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (step) begin
            val_q <= (val_q == LAST) ? '0 : val_q + 1'b1;
        end
    end

    assign value   = val_q;
    assign at_last = (val_q == LAST);

    p_count_bounded_r6: assert property (@(posedge clk) disable iff (rst)
        val_q <= LAST);

endmodule

// File: rtl/init_cmd_driver.sv
module init_cmd_driver
    import dram_init_pkg::*;
#(
    parameter int unsigned BANK_W = 3,
    parameter int unsigned MODE_W = 18
) (
    input  init_state_e        state,
    input  logic [BANK_W-1:0]  bank_idx,
    input  logic               mrs_is_valid,
    input  logic [MODE_W-1:0]  mode_cfg,
    output dram_cmd_e          cmd,
    output logic [BANK_W-1:0]  bank,
    output logic [MODE_W-1:0]  mode
);
    always_comb begin
        cmd  = CMD_NOP;
        bank = '0;
        mode = '0;
        unique case (state)
            ST_MRS: begin
                cmd = CMD_MRS;
                if (mrs_is_valid) begin
                    mode = mode_cfg;
                end
            end
            ST_REF: begin
                cmd  = CMD_REF;
                bank = bank_idx;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end
endmodule

// File: rtl/dram_powerup_seq.sv
module dram_powerup_seq
    import dram_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 400,
    parameter int unsigned STABLE_US = 200,
    parameter int unsigned T_MRSC    = 6,
    parameter int unsigned MRS_GAP   = T_MRSC,
    parameter int unsigned REF_GAP   = 2048,
    parameter int unsigned T_RC      = 8,
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned MODE_W    = 18,
    localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok_i,
    input  logic [MODE_W-1:0] mode_cfg_i,
    output logic [1:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              ready_o
);
    // All gap parameters are start-to-start distances and must be >= 2.
    localparam int unsigned STABLE_CYC = cycles_from_us(STABLE_US, CLK_MHZ);
    localparam int unsigned MRS_COUNT  = 3;
    localparam int unsigned TMR_MAX    = max5(STABLE_CYC, MRS_GAP, T_MRSC, REF_GAP, T_RC);
    localparam int unsigned TMR_W      = $clog2(TMR_MAX + 1);

    localparam logic [TMR_W-1:0] LD_STABLE = TMR_W'(STABLE_CYC - 1);
    localparam logic [TMR_W-1:0] LD_MRS    = TMR_W'(MRS_GAP - 2);
    localparam logic [TMR_W-1:0] LD_SETTLE = TMR_W'(T_MRSC - 2);
    localparam logic [TMR_W-1:0] LD_REF    = TMR_W'(REF_GAP - 2);
    localparam logic [TMR_W-1:0] LD_RC     = TMR_W'(T_RC - 2);

    init_state_e        state_q, state_d;
    seq_ctrl_t          ctrl;
    logic [TMR_W-1:0]   load_val;
    logic               tmr_expired;
    logic [1:0]         mrs_idx;
    logic               mrs_last;
    logic [BANK_W-1:0]  bank_idx;
    logic               bank_last;
    dram_cmd_e          cmd;

    init_interval_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ctrl.load),
        .load_val (load_val),
        .expired  (tmr_expired)
    );

    init_event_counter #(.COUNT(MRS_COUNT)) u_mrs_cnt (
        .clk     (clk),
        .rst     (rst),
        .step    (ctrl.mrs_step),
        .value   (mrs_idx),
        .at_last (mrs_last)
    );

    init_event_counter #(.COUNT(NUM_BANKS)) u_bank_cnt (
        .clk     (clk),
        .rst     (rst),
        .step    (ctrl.bank_step),
        .value   (bank_idx),
        .at_last (bank_last)
    );

    always_comb begin
        state_d  = state_q;
        ctrl     = '0;
        load_val = '0;
        unique case (state_q)
            ST_WAIT_SUPPLY: begin
                if (supply_ok_i) begin
                    state_d   = ST_STABLE;
                    ctrl.load = 1'b1;
                    load_val  = LD_STABLE;
                end
            end
            ST_STABLE: begin
                if (tmr_expired) state_d = ST_MRS;
            end
            ST_MRS: begin
                ctrl.mrs_step = 1'b1;
                ctrl.load     = 1'b1;
                if (mrs_last) begin
                    state_d  = ST_MRS_SETTLE;
                    load_val = LD_SETTLE;
                end else begin
                    state_d  = ST_MRS_GAP;
                    load_val = LD_MRS;
                end
            end
            ST_MRS_GAP: begin
                if (tmr_expired) state_d = ST_MRS;
            end
            ST_MRS_SETTLE: begin
                if (tmr_expired) state_d = ST_REF;
            end
            ST_REF: begin
                ctrl.bank_step = 1'b1;
                ctrl.load      = 1'b1;
                if (bank_last) begin
                    state_d  = ST_ROW_CYCLE;
                    load_val = LD_RC;
                end else begin
                    state_d  = ST_REF_GAP;
                    load_val = LD_REF;
                end
            end
            ST_REF_GAP: begin
                if (tmr_expired) state_d = ST_REF;
            end
            ST_ROW_CYCLE: begin
                if (tmr_expired) state_d = ST_READY;
            end
            ST_READY: begin
                state_d = ST_READY;
            end
            default: begin
                state_d = ST_WAIT_SUPPLY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_SUPPLY;
        end else begin
            state_q <= state_d;
        end
    end

    init_cmd_driver #(.BANK_W(BANK_W), .MODE_W(MODE_W)) u_drv (
        .state        (state_q),
        .bank_idx     (bank_idx),
        .mrs_is_valid (mrs_last),
        .mode_cfg     (mode_cfg_i),
        .cmd          (cmd),
        .bank         (bank_o),
        .mode         (mode_o)
    );

    assign cmd_o   = cmd;
    assign ready_o = (state_q == ST_READY);

    // Refresh spacing monitor: saturating distance since the last refresh.
    localparam int unsigned SINCE_W = $clog2(REF_GAP + 1);
    localparam logic [SINCE_W-1:0] SINCE_MAX = SINCE_W'(REF_GAP);
    logic [SINCE_W-1:0] since_ref_q;
    logic               seen_ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_ref_q <= '0;
            seen_ref_q  <= 1'b0;
        end else if (cmd_o == CMD_REF) begin
            since_ref_q <= SINCE_W'(1);
            seen_ref_q  <= 1'b1;
        end else if (since_ref_q < SINCE_MAX) begin
            since_ref_q <= since_ref_q + 1'b1;
        end
    end

    p_idle_wait_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_SUPPLY) |-> (cmd_o == CMD_NOP && !ready_o && mode_o == '0));

    p_mrs_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_MRS) |=> (cmd_o == CMD_NOP));

    p_mode_only_mrs_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_o != '0) |-> (cmd_o == CMD_MRS));

    p_bank_only_ref_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != CMD_REF) |-> (bank_o == '0));

    p_ref_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_REF && seen_ref_q) |-> (since_ref_q >= SINCE_MAX));

    p_ready_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> ready_o);

    p_ready_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (cmd_o == CMD_NOP));

    p_cmd_legal_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_NOP) || (cmd_o == CMD_MRS) || (cmd_o == CMD_REF));

endmodule

// File: tb/tb_dram_powerup_seq.sv
module tb_dram_powerup_seq;
    localparam int CLK_MHZ   = 4;
    localparam int STABLE_US = 2;
    localparam int T_MRSC    = 5;
    localparam int MRS_GAP   = 3;
    localparam int REF_GAP   = 16;
    localparam int T_RC      = 6;
    localparam int NUM_BANKS = 8;
    localparam int MODE_W    = 18;
    localparam int BANK_W    = 3;

    localparam int S_CYC  = STABLE_US * CLK_MHZ;
    localparam int TM0    = 1 + S_CYC;
    localparam int TM2    = TM0 + 2 * MRS_GAP;
    localparam int TR0    = TM2 + T_MRSC;
    localparam int TRLAST = TR0 + (NUM_BANKS - 1) * REF_GAP;
    localparam int TRDY   = TRLAST + T_RC;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst;
    logic              supply_ok;
    logic [MODE_W-1:0] mode_cfg;
    logic [1:0]        cmd;
    logic [BANK_W-1:0] bank;
    logic [MODE_W-1:0] mode;
    logic              ready;

    int vectors = 0;
    int miscompares = 0;

    dram_powerup_seq #(
        .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .T_MRSC(T_MRSC),
        .MRS_GAP(MRS_GAP), .REF_GAP(REF_GAP), .T_RC(T_RC),
        .NUM_BANKS(NUM_BANKS), .MODE_W(MODE_W)
    ) dut (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .mode_cfg_i(mode_cfg),
        .cmd_o(cmd), .bank_o(bank), .mode_o(mode), .ready_o(ready)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_cmd(input int k);
        for (int i = 0; i < 3; i++) if (k == TM0 + i * MRS_GAP) return 1;
        for (int b = 0; b < NUM_BANKS; b++) if (k == TR0 + b * REF_GAP) return 2;
        return 0;
    endfunction

    function automatic int exp_bank(input int k);
        for (int b = 0; b < NUM_BANKS; b++) if (k == TR0 + b * REF_GAP) return b;
        return 0;
    endfunction

    function automatic int exp_mode(input int k, input int cfg);
        return (k == TM2) ? cfg : 0;
    endfunction

    function automatic string cmd_tag(input int k);
        if (k < TM0) return "R2";
        if (exp_cmd(k) == 1) return "R3";
        if (k == TR0) return "R5";
        if (exp_cmd(k) == 2) return "R6";
        if (k >= TRDY) return "R7";
        return "R8";
    endfunction

    // Caller raises supply at a negedge; cycle k is sampled after the k-th rising edge.
    task automatic trace(input int cfg, input int last_k);
        for (int k = 1; k <= last_k; k++) begin
            @(negedge clk);
            chk(cmd_tag(k), $sformatf("cmd k=%0d", k), int'(cmd), exp_cmd(k));
            chk("R6", $sformatf("bank k=%0d", k), int'(bank), exp_bank(k));
            chk("R4", $sformatf("mode k=%0d", k), int'(mode), exp_mode(k, cfg));
            chk("R7", $sformatf("ready k=%0d", k), int'(ready), (k >= TRDY) ? 1 : 0);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(tag, "idle cmd", int'(cmd), 0);
        chk(tag, "idle bank", int'(bank), 0);
        chk(tag, "idle mode", int'(mode), 0);
        chk(tag, "idle ready", int'(ready), 0);
    endtask

    task automatic reset_and_wait(input int n);
        @(negedge clk);
        rst = 1'b1;
        supply_ok = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_idle("R1");
        end
    endtask

    initial begin
        #(8 * 200000);
        miscompares++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int cfgs[4];
        cfgs[0] = 18'h00001;
        cfgs[1] = 18'h2AAAA;
        cfgs[2] = 18'h3FFFF;
        cfgs[3] = 18'h15555;
        rst = 1'b1;
        supply_ok = 1'b0;
        mode_cfg = '0;

        // Sweep supply delay and mode value (R1..R8).
        for (int c = 0; c < 4; c++) begin
            for (int d = 1; d <= 3; d++) begin
                mode_cfg = MODE_W'(cfgs[c]);
                reset_and_wait(d);
                supply_ok = 1'b1;
                trace(cfgs[c], TRDY + 8);
            end
        end

        // R9: reset in the middle of the refresh phase, supply kept high.
        mode_cfg = MODE_W'(cfgs[1]);
        reset_and_wait(2);
        supply_ok = 1'b1;
        trace(cfgs[1], TR0 + 3 * REF_GAP + 2);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R9");
        rst = 1'b0;
        mode_cfg = MODE_W'(cfgs[3]);
        trace(cfgs[3], TRDY + 4);

        // R9: reset after ready clears it; R1: holds idle while supply low.
        rst = 1'b1;
        supply_ok = 1'b0;
        @(negedge clk);
        check_idle("R9");
        rst = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check_idle("R1");
        end
        supply_ok = 1'b1;
        trace(cfgs[3], TRDY + 4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule